// File: doc/BRIEF.md
# SPI Chip-Select Generator

This block produces the select lines for an SPI master with several attached devices. A small index field chooses one target line. In automatic mode the chosen line is asserted while the transfer engine reports a burst in progress. It then stays asserted for a programmable hold of half a bit time after the last bit. In manual mode software drives the chosen line directly with a raw level bit, and the burst indication has no effect on that line.

A polarity input states whether the select lines are active low or active high. The same input also fixes the resting level of every line that is not chosen, in both modes. All outputs are registered and change one clock after the inputs that cause them. The index is sampled only while no burst or hold tail is running, so a device cannot be deselected in the middle of a burst. The block has no data path, so it has no valid/ready interface. All its pins are plain control and status levels.

Top module: `spi_cs_gen`

## Requirements
- R1: While `rst_n` is low, at the next clock edge every select line takes the inactive level: all ones when `active_low` is 1 and all zeros when it is 0.
- R2: With `active_low` = 1, unselected lines rest at 1 and an asserted line is driven to 0.
- R3: With `active_low` = 0, unselected lines rest at 0 and an asserted line is driven to 1.
- R4: The index value i (0 to 3) chooses output bit i of `cs_lines`. No other bit ever leaves the idle level.
- R5: In automatic mode (`manual_en` = 0), the chosen line asserts one clock after `burst_busy` is first sampled high. It stays asserted for N + H clocks, where N is the number of clocks `burst_busy` is high and H is `half_bit_cycles`. It then returns to idle.
- R6: When `half_bit_cycles` = 0, the automatic assertion lasts exactly N clocks.
- R7: A change of `cs_index` while a burst or its hold tail is running does not move the asserted line. The new index is taken only once the block is idle.
- R8: In manual mode (`manual_en` = 1), the chosen line is driven to `manual_level` as given, one clock after the settings, whether or not `burst_busy` is high.
- R9: In manual mode with `active_low` = 0, the unselected lines stay at 0 even when `manual_level` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_index | input | 2 | Target device number |
| manual_en | input | 1 | 1: software drives the chosen line; 0: burst-driven |
| manual_level | input | 1 | Raw level put on the chosen line in manual mode |
| active_low | input | 1 | 1: lines assert low and idle high; 0: assert high, idle low |
| burst_busy | input | 1 | High while the transfer engine shifts a burst |
| half_bit_cycles | input | 8 | Hold time after the burst, in clocks |
| cs_lines | output | 4 | Chip-select outputs, bit i for device i |

## Verification
The automatic path is swept over every index, both polarities, burst lengths of one to three clocks and hold values of zero to two. Each sweep point checks all four lines on every clock. This separates an off-by-one in the hold from one in the start, and it shows a wrong line or wrong polarity at once. The manual path is swept over index, polarity, raw level and burst activity. This shows that the raw bit is taken without inversion, that it ignores the burst, and that the idle level still follows polarity. A burst whose index changes mid-flight shows that the asserted line is frozen until the tail has ended.

// File: rtl/spi_cs_pkg.sv
`timescale 1ns/1ps
package spi_cs_pkg;
  typedef enum logic {
    POL_ACT_HIGH = 1'b0,
    POL_ACT_LOW  = 1'b1
  } cs_pol_e;

  function automatic logic idle_level(input logic act_low);
    return act_low;
  endfunction
endpackage

// File: rtl/cs_index_hold.sv
`timescale 1ns/1ps
module cs_index_hold #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             engaged,
  input  logic [SEL_W-1:0] idx_in,
  output logic [SEL_W-1:0] sel_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        sel_q <= '0;
    else if (!engaged) sel_q <= idx_in;
  end

  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    engaged |=> $stable(sel_q)); // R7
  AST_SEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    !engaged |=> sel_q == $past(idx_in)); // R4
endmodule

// File: rtl/cs_tail_timer.sv
`timescale 1ns/1ps
module cs_tail_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic [CNT_W-1:0] hold_cycles,
  output logic             engaged
);
  logic [CNT_W-1:0] tail_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           tail_q <= '0;
    else if (busy)        tail_q <= hold_cycles;
    else if (tail_q != 0) tail_q <= tail_q - 1'b1;
  end

  assign engaged = busy || (tail_q != '0);

  AST_TAIL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> tail_q == $past(hold_cycles)); // R5
  AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tail_q != '0) |=> tail_q == $past(tail_q) - 1'b1); // R5
endmodule

// File: rtl/cs_line_drive.sv
`timescale 1ns/1ps
module cs_line_drive
  import spi_cs_pkg::*;
#(
  parameter int LINES = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             manual_en,
  input  logic             manual_level,
  input  logic             active_low,
  input  logic             engaged,
  output logic [LINES-1:0] cs_q
);
  logic rest_lvl;
  assign rest_lvl = idle_level(active_low);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic nxt;
    always_comb begin
      nxt = rest_lvl;
      if (sel == SEL_W'(g)) begin
        if (manual_en)    nxt = manual_level;
        else if (engaged) nxt = ~rest_lvl;
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n) cs_q[g] <= rest_lvl;
      else        cs_q[g] <= nxt;
    end
  end

  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs_q ^ {LINES{$past(active_low)}}) <= 1); // R2
  AST_AUTO_ASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual_en && engaged) |=> cs_q[$past(sel)] == !$past(active_low)); // R5
endmodule

// File: rtl/spi_cs_gen.sv
`timescale 1ns/1ps
module spi_cs_gen #(
  parameter int LINES  = 4,
  parameter int TAIL_W = 8,
  localparam int SEL_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  cs_index,
  input  logic              manual_en,
  input  logic              manual_level,
  input  logic              active_low,
  input  logic              burst_busy,
  input  logic [TAIL_W-1:0] half_bit_cycles,
  output logic [LINES-1:0]  cs_lines
);
  logic             engaged;
  logic [SEL_W-1:0] sel_q;

  cs_tail_timer #(.CNT_W(TAIL_W)) u_tail (
    .clk(clk), .rst_n(rst_n), .busy(burst_busy),
    .hold_cycles(half_bit_cycles), .engaged(engaged)
  );

  cs_index_hold #(.SEL_W(SEL_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .engaged(engaged),
    .idx_in(cs_index), .sel_q(sel_q)
  );

  cs_line_drive #(.LINES(LINES), .SEL_W(SEL_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .sel(sel_q), .manual_en(manual_en),
    .manual_level(manual_level), .active_low(active_low),
    .engaged(engaged), .cs_q(cs_lines)
  );

  AST_MANUAL_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    manual_en |=> cs_lines[$past(sel_q)] == $past(manual_level)); // R8
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> cs_lines == {LINES{$past(active_low)}}); // R1
endmodule

// File: tb/sim_spi_cs_gen.sv
`timescale 1ns/1ps
module sim_spi_cs_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cs_index = '0;
  logic       manual_en = 1'b0;
  logic       manual_level = 1'b0;
  logic       active_low = 1'b1;
  logic       burst_busy = 1'b0;
  logic [7:0] half_bit_cycles = '0;
  logic [3:0] cs_lines;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  spi_cs_gen u0 (
    .clk(clk), .rst_n(rst_n), .cs_index(cs_index), .manual_en(manual_en),
    .manual_level(manual_level), .active_low(active_low),
    .burst_busy(burst_busy), .half_bit_cycles(half_bit_cycles),
    .cs_lines(cs_lines)
  );

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: cs_lines=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic auto_burst(input int idx, input int n, input int h,
                            input bit pol, input int chg, input string req);
    logic [3:0] exp;
    manual_en = 1'b0; burst_busy = 1'b0;
    cs_index = 2'(idx); active_low = pol; half_bit_cycles = 8'(h);
    repeat (h + 4) @(negedge clk);
    burst_busy = 1'b1;
    for (int k = 1; k <= n + h + 2; k++) begin
      @(negedge clk);
      exp = {4{pol}};
      if (k <= n + h) exp[idx] = ~pol;
      chk(req, cs_lines, exp);
      burst_busy = (k < n);
      if (k == 2 && chg >= 0) cs_index = 2'(chg);
    end
  endtask

  task automatic man_chk(input int idx, input bit pol, input bit lvl, input bit bsy);
    logic [3:0] exp;
    manual_en = 1'b1; burst_busy = 1'b0; half_bit_cycles = '0;
    cs_index = 2'(idx); active_low = pol; manual_level = lvl;
    repeat (2) @(negedge clk);
    burst_busy = bsy;
    repeat (2) @(negedge clk);
    exp = {4{pol}};
    exp[idx] = lvl;
    chk((!pol && lvl) ? "R9" : "R8", cs_lines, exp);
    burst_busy = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    // R1 reset with both polarities
    active_low = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", cs_lines, 4'hF);
    active_low = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", cs_lines, 4'h0);
    active_low = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", cs_lines, 4'hF);

    // R2 R3 R4 R5 R6: automatic sweep
    for (int pol = 0; pol < 2; pol++)
      for (int idx = 0; idx < 4; idx++)
        for (int n = 1; n <= 3; n++)
          for (int h = 0; h <= 2; h++)
            auto_burst(idx, n, h, pol[0], -1,
                       (h == 0) ? "R6" : (pol == 0 ? "R3/R4/R5" : "R2/R4/R5"));

    // R7: index change during burst and tail is ignored
    auto_burst(1, 4, 2, 1'b1, 3, "R7");
    auto_burst(2, 3, 3, 1'b0, 0, "R7");
    // new index applies once idle
    manual_en = 1'b1; manual_level = 1'b1; active_low = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7", cs_lines, 4'b0001);

    // R8 R9: manual sweep
    for (int pol = 0; pol < 2; pol++)
      for (int idx = 0; idx < 4; idx++)
        for (int lvl = 0; lvl < 2; lvl++)
          for (int b = 0; b < 2; b++)
            man_chk(idx, pol[0], lvl[0], b[0]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule